// File: doc/BRIEF.md
# Buffer Command Link Serializer and Deserializer

This block carries commands from a register device to a data buffer over a narrow point-to-point link of nine signals. The sending side takes one command per valid/ready handshake. A command is a 2-bit kind, a 2-bit header and a 12-bit word. It sends the command as five back-to-back 4-bit transfers, followed by one cycle that carries an even parity bit. The receiving side rebuilds the burst and checks its integrity. A control word goes into a 16-entry by 8-bit function space. A read, write or mode-register command is flagged to downstream logic for one cycle.

Both halves sit in one top module and run on one clock. The link is brought out as a separate output group and input group. The integrator connects the two groups, either directly or through the physical path. The request interface applies back-pressure in one simple way: `req_ready` is high only while the sender is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. A request presented while `req_ready` is low is never queued. It has no effect unless it is still held when `req_ready` returns. The requester may change or drop the request at any time without corrupting a burst in flight.

Kind codes are 0 for a control word, 1 for read, 2 for write and 3 for mode-register set.

Top module: `ctl_link`

## Requirements
- R1: After reset, `req_ready` is 1, `lk_stb_o`, `lk_par_o`, `lk_rsv_o`, `cmd_pulse` and `par_err` are 0, and every function-space entry reads 0.
- R2: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. Transfer 0 appears in the next cycle. `req_ready` stays low through all six burst cycles and is high again in the cycle after the parity cycle.
- R3: A burst drives `lk_stb_o` high for exactly five cycles, then one parity cycle with the strobe low. Transfer 0 is {kind, header}, with kind in bits [3:2]. Transfers 1 to 3 carry word bits [11:8], [7:4] and [3:0]. Transfer 4 is zero. `lk_kind_o` carries the kind during all five transfers, and `lk_rsv_o` stays 0.
- R4: In the parity cycle, `lk_par_o` equals the XOR of all 20 transferred bits, which gives even parity.
- R5: A burst of kind 0 that is received intact writes word[7:0] into function-space entry word[11:8]. The new value can be read through `fs_addr`/`fs_rdata` in the cycle after the parity cycle. Later writes to the same entry overwrite it.
- R6: A burst of kind 1, 2 or 3 that is received intact raises `cmd_pulse` for one cycle, in the cycle after the parity cycle, with `cmd_kind`, `cmd_hdr` and `cmd_word` equal to the sent values. It writes no function-space entry. A kind-0 burst never raises `cmd_pulse`.
- R7: If the received parity does not match the 20 received bits, the burst is discarded. `par_err` is high for exactly one cycle, in the cycle after the parity cycle. `cmd_pulse` stays low and the function space is unchanged.
- R8: The burst is discarded and flagged exactly as in R7 in any of these cases: `lk_kind_i` differs from bits [3:2] of transfer 0, `lk_rsv_i` is high in any burst cycle, or the spare bits of transfer 4 are non-zero.
- R9: A request presented while a burst is in flight does not alter that burst. If the request is dropped before `req_ready` returns, no burst follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sender idle, request can be taken |
| req_kind | input | 2 | Command kind (0 ctrl, 1 read, 2 write, 3 mode) |
| req_hdr | input | 2 | Header bits |
| req_word | input | 12 | Command word |
| lk_dat_o | output | 4 | Link data nibble, sending side |
| lk_stb_o | output | 1 | Link transfer strobe, sending side |
| lk_par_o | output | 1 | Link parity line, sending side |
| lk_kind_o | output | 2 | Link kind lines, sending side |
| lk_rsv_o | output | 1 | Reserved line, held low |
| lk_dat_i | input | 4 | Link data nibble, receiving side |
| lk_stb_i | input | 1 | Link transfer strobe, receiving side |
| lk_par_i | input | 1 | Link parity line, receiving side |
| lk_kind_i | input | 2 | Link kind lines, receiving side |
| lk_rsv_i | input | 1 | Reserved line, receiving side |
| fs_addr | input | 4 | Function-space read address |
| fs_rdata | output | 8 | Function-space read data |
| cmd_pulse | output | 1 | Tracked command received |
| cmd_kind | output | 2 | Kind of tracked command |
| cmd_hdr | output | 2 | Header of tracked command |
| cmd_word | output | 12 | Word of tracked command |
| par_err | output | 1 | Burst discarded on integrity error |

## Verification
A vector table sends every kind with mixed header values. The words are chosen so each nibble position holds a distinct value, so a swapped or misordered transfer shows up. Words with odd and even bit counts are included, so both parity values are tried. Two control words hit the same entry, which separates a true overwrite from a write to the wrong entry. Directed bursts then corrupt one element each: a data bit, the parity line, the kind lines, and the reserved line. These show that each integrity check discards the burst by itself, with no write and no tracked pulse. A request held through a burst with a different word shows that the in-flight transfers are unchanged and that no request is queued. Bursts sent back to back exercise the idle turnaround between them.

// File: rtl/ctl_link_pkg.sv
package ctl_link_pkg;
  localparam int NIB_W  = 4;
  localparam int BEATS  = 5;
  localparam int KIND_W = 2;
  localparam int HDR_W  = 2;
  localparam int WORD_W = 12;
  localparam int FS_AW  = 4;
  localparam int FS_DW  = 8;

  typedef enum logic [KIND_W-1:0] {
    KIND_CTRL  = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_MODE  = 2'd3
  } kind_e;
endpackage

// File: rtl/ctl_link_tx.sv
module ctl_link_tx #(
  parameter int NIB_W  = ctl_link_pkg::NIB_W,
  parameter int BEATS  = ctl_link_pkg::BEATS,
  parameter int KIND_W = ctl_link_pkg::KIND_W,
  parameter int HDR_W  = ctl_link_pkg::HDR_W,
  parameter int WORD_W = ctl_link_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [HDR_W-1:0]  req_hdr,
  input  logic [WORD_W-1:0] req_word,
  output logic [NIB_W-1:0]  lk_dat,
  output logic              lk_stb,
  output logic              lk_par,
  output logic [KIND_W-1:0] lk_kind,
  output logic              lk_rsv
);
  localparam int FRAME_W = NIB_W * BEATS;
  localparam int PAD_W   = FRAME_W - KIND_W - HDR_W - WORD_W;
  localparam int CNT_W   = $clog2(BEATS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS);

  logic               busy;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;
  logic               par_q;
  logic [KIND_W-1:0]  kind_q;
  logic [FRAME_W-1:0] frame;
  logic               take;

  assign frame = {req_kind, req_hdr, req_word, {PAD_W{1'b0}}};
  assign take  = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      par_q  <= 1'b0;
      kind_q <= '0;
    end else if (take) begin
      busy   <= 1'b1;
      cnt    <= '0;
      shreg  <= frame;
      par_q  <= ^frame;
      kind_q <= req_kind;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt   <= cnt + 1'b1;
        shreg <= shreg << NIB_W;
      end
    end
  end

  assign req_ready = !busy;
  assign lk_stb    = busy && (cnt != LAST);
  assign lk_dat    = lk_stb ? shreg[FRAME_W-1 -: NIB_W] : '0;
  assign lk_par    = busy && (cnt == LAST) && par_q;
  assign lk_kind   = lk_stb ? kind_q : '0;
  assign lk_rsv    = 1'b0;

  // R2: an accepted request starts a burst in the next cycle
  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (lk_stb && !req_ready));

  // R3: the strobe stays high for exactly five cycles
  p_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lk_stb) |-> ($past(lk_stb, 5) && !$past(lk_stb, 6)));
endmodule

// File: rtl/ctl_link_rx.sv
module ctl_link_rx #(
  parameter int NIB_W  = ctl_link_pkg::NIB_W,
  parameter int BEATS  = ctl_link_pkg::BEATS,
  parameter int KIND_W = ctl_link_pkg::KIND_W,
  parameter int HDR_W  = ctl_link_pkg::HDR_W,
  parameter int WORD_W = ctl_link_pkg::WORD_W,
  parameter int FS_AW  = ctl_link_pkg::FS_AW,
  parameter int FS_DW  = ctl_link_pkg::FS_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  lk_dat,
  input  logic              lk_stb,
  input  logic              lk_par,
  input  logic [KIND_W-1:0] lk_kind,
  input  logic              lk_rsv,
  output logic              fs_we,
  output logic [FS_AW-1:0]  fs_waddr,
  output logic [FS_DW-1:0]  fs_wdata,
  output logic              cmd_pulse,
  output logic [KIND_W-1:0] cmd_kind,
  output logic [HDR_W-1:0]  cmd_hdr,
  output logic [WORD_W-1:0] cmd_word,
  output logic              par_err
);
  import ctl_link_pkg::*;
  localparam int FRAME_W = NIB_W * BEATS;
  localparam int PAD_W   = FRAME_W - KIND_W - HDR_W - WORD_W;
  localparam int CNT_W   = $clog2(BEATS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS);

  logic               run;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh;
  logic               bad;
  logic               at_par;
  logic               good;
  logic [KIND_W-1:0]  f_kind;
  logic [HDR_W-1:0]   f_hdr;
  logic [WORD_W-1:0]  f_word;
  logic [PAD_W-1:0]   f_pad;

  assign f_kind = sh[FRAME_W-1 -: KIND_W];
  assign f_hdr  = sh[FRAME_W-KIND_W-1 -: HDR_W];
  assign f_word = sh[FRAME_W-KIND_W-HDR_W-1 -: WORD_W];
  assign f_pad  = sh[PAD_W-1:0];

  assign at_par = run && (cnt == LAST);
  assign good   = at_par && !bad && !lk_rsv && (f_pad == '0) && ((^sh) == lk_par);

  assign fs_we    = good && (kind_e'(f_kind) == KIND_CTRL);
  assign fs_waddr = f_word[WORD_W-1 -: FS_AW];
  assign fs_wdata = f_word[FS_DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      bad       <= 1'b0;
      cmd_pulse <= 1'b0;
      cmd_kind  <= '0;
      cmd_hdr   <= '0;
      cmd_word  <= '0;
      par_err   <= 1'b0;
    end else begin
      cmd_pulse <= 1'b0;
      par_err   <= 1'b0;
      if (!run) begin
        if (lk_stb) begin
          run <= 1'b1;
          cnt <= CNT_W'(1);
          sh  <= {sh[FRAME_W-NIB_W-1:0], lk_dat};
          bad <= lk_rsv || (lk_kind != lk_dat[NIB_W-1 -: KIND_W]);
        end
      end else if (cnt != LAST) begin
        cnt <= cnt + 1'b1;
        sh  <= {sh[FRAME_W-NIB_W-1:0], lk_dat};
        bad <= bad || lk_rsv || !lk_stb;
      end else begin
        run     <= 1'b0;
        cnt     <= '0;
        par_err <= !good;
        if (good && (kind_e'(f_kind) != KIND_CTRL)) begin
          cmd_pulse <= 1'b1;
          cmd_kind  <= f_kind;
          cmd_hdr   <= f_hdr;
          cmd_word  <= f_word;
        end
      end
    end
  end

  // R7: a discarded burst never also reports a tracked command
  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_err && cmd_pulse));

  // R7: the error flag lasts one cycle
  p_err_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> !par_err);

  // R6: the tracked-command flag lasts one cycle
  p_cmd_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse |=> !cmd_pulse);
endmodule

// File: rtl/ctl_link_fspace.sv
module ctl_link_fspace #(
  parameter int FS_AW = ctl_link_pkg::FS_AW,
  parameter int FS_DW = ctl_link_pkg::FS_DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [FS_AW-1:0] waddr,
  input  logic [FS_DW-1:0] wdata,
  input  logic [FS_AW-1:0] raddr,
  output logic [FS_DW-1:0] rdata
);
  localparam int DEPTH = 1 << FS_AW;

  logic [DEPTH-1:0][FS_DW-1:0] regs;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[i] <= '0;
      end else if (we && (waddr == FS_AW'(i))) begin
        regs[i] <= wdata;
      end
    end
  end

  assign rdata = regs[raddr];

  // R7: without a write strobe the array keeps its contents
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs));
endmodule

// File: rtl/ctl_link.sv
module ctl_link #(
  parameter int NIB_W  = ctl_link_pkg::NIB_W,
  parameter int BEATS  = ctl_link_pkg::BEATS,
  parameter int KIND_W = ctl_link_pkg::KIND_W,
  parameter int HDR_W  = ctl_link_pkg::HDR_W,
  parameter int WORD_W = ctl_link_pkg::WORD_W,
  parameter int FS_AW  = ctl_link_pkg::FS_AW,
  parameter int FS_DW  = ctl_link_pkg::FS_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [HDR_W-1:0]  req_hdr,
  input  logic [WORD_W-1:0] req_word,
  output logic [NIB_W-1:0]  lk_dat_o,
  output logic              lk_stb_o,
  output logic              lk_par_o,
  output logic [KIND_W-1:0] lk_kind_o,
  output logic              lk_rsv_o,
  input  logic [NIB_W-1:0]  lk_dat_i,
  input  logic              lk_stb_i,
  input  logic              lk_par_i,
  input  logic [KIND_W-1:0] lk_kind_i,
  input  logic              lk_rsv_i,
  input  logic [FS_AW-1:0]  fs_addr,
  output logic [FS_DW-1:0]  fs_rdata,
  output logic              cmd_pulse,
  output logic [KIND_W-1:0] cmd_kind,
  output logic [HDR_W-1:0]  cmd_hdr,
  output logic [WORD_W-1:0] cmd_word,
  output logic              par_err
);
  logic             wr_en;
  logic [FS_AW-1:0] wr_addr;
  logic [FS_DW-1:0] wr_data;

  ctl_link_tx #(
    .NIB_W(NIB_W), .BEATS(BEATS), .KIND_W(KIND_W), .HDR_W(HDR_W), .WORD_W(WORD_W)
  ) u_tx (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_hdr(req_hdr), .req_word(req_word),
    .lk_dat(lk_dat_o), .lk_stb(lk_stb_o), .lk_par(lk_par_o),
    .lk_kind(lk_kind_o), .lk_rsv(lk_rsv_o)
  );

  ctl_link_rx #(
    .NIB_W(NIB_W), .BEATS(BEATS), .KIND_W(KIND_W), .HDR_W(HDR_W), .WORD_W(WORD_W),
    .FS_AW(FS_AW), .FS_DW(FS_DW)
  ) u_rx (
    .clk(clk), .rst_n(rst_n),
    .lk_dat(lk_dat_i), .lk_stb(lk_stb_i), .lk_par(lk_par_i),
    .lk_kind(lk_kind_i), .lk_rsv(lk_rsv_i),
    .fs_we(wr_en), .fs_waddr(wr_addr), .fs_wdata(wr_data),
    .cmd_pulse(cmd_pulse), .cmd_kind(cmd_kind), .cmd_hdr(cmd_hdr),
    .cmd_word(cmd_word), .par_err(par_err)
  );

  ctl_link_fspace #(
    .FS_AW(FS_AW), .FS_DW(FS_DW)
  ) u_fs (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(fs_addr), .rdata(fs_rdata)
  );
endmodule

// File: tb/tb_ctl_link.sv
module tb_ctl_link;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_hdr = '0;
  logic [11:0] req_word = '0;
  logic [3:0]  lk_dat_o, lk_dat_i;
  logic        lk_stb_o, lk_stb_i, lk_par_o, lk_par_i, lk_rsv_o, lk_rsv_i;
  logic [1:0]  lk_kind_o, lk_kind_i;
  logic [3:0]  fs_addr = '0;
  logic [7:0]  fs_rdata;
  logic        cmd_pulse, par_err;
  logic [1:0]  cmd_kind, cmd_hdr;
  logic [11:0] cmd_word;

  logic [3:0]  inj_dat = '0;
  logic        inj_par = 1'b0;
  logic [1:0]  inj_kind = '0;
  logic        inj_rsv = 1'b0;

  assign lk_dat_i  = lk_dat_o ^ inj_dat;
  assign lk_stb_i  = lk_stb_o;
  assign lk_par_i  = lk_par_o ^ inj_par;
  assign lk_kind_i = lk_kind_o ^ inj_kind;
  assign lk_rsv_i  = lk_rsv_o | inj_rsv;

  always #4 clk = ~clk;

  ctl_link dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_hdr(req_hdr), .req_word(req_word),
    .lk_dat_o(lk_dat_o), .lk_stb_o(lk_stb_o), .lk_par_o(lk_par_o),
    .lk_kind_o(lk_kind_o), .lk_rsv_o(lk_rsv_o),
    .lk_dat_i(lk_dat_i), .lk_stb_i(lk_stb_i), .lk_par_i(lk_par_i),
    .lk_kind_i(lk_kind_i), .lk_rsv_i(lk_rsv_i),
    .fs_addr(fs_addr), .fs_rdata(fs_rdata),
    .cmd_pulse(cmd_pulse), .cmd_kind(cmd_kind), .cmd_hdr(cmd_hdr),
    .cmd_word(cmd_word), .par_err(par_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] model [16];

  // {kind[1:0], hdr[1:0], word[11:0]}
  localparam logic [15:0] VEC [8] = '{
    16'h03A5, 16'h3F00, 16'h5ABC, 16'hA123,
    16'hCFFF, 16'h13C3, 16'h20FF, 16'hF000
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // mode: 0 clean, 1 data bit flip, 2 parity flip, 3 kind-line mismatch, 4 reserved high
  task automatic frame(input logic [1:0] k, input logic [1:0] h, input logic [11:0] w,
                       input int mode, input bit hold);
    logic [19:0] fr;
    logic        exp_par;
    bit          ok;
    fr = {k, h, w, 4'h0};
    exp_par = ^fr;
    ok = (mode == 0);
    @(negedge clk);
    check("R2 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_kind = k; req_hdr = h; req_word = w;
    @(negedge clk);
    if (hold) begin
      req_kind = ~k; req_hdr = ~h; req_word = ~w;
    end else begin
      req_valid = 1'b0;
    end
    for (int i = 0; i < 5; i++) begin
      if (i > 0) @(negedge clk);
      check($sformatf("R3 strobe transfer %0d", i), 32'(lk_stb_o), 32'd1);
      check($sformatf("R3 R9 nibble %0d", i), 32'(lk_dat_o), 32'(fr[19-4*i -: 4]));
      check("R3 kind lines", 32'(lk_kind_o), 32'(k));
      check("R3 reserved low", 32'(lk_rsv_o), 32'd0);
      check("R2 ready low in burst", 32'(req_ready), 32'd0);
      inj_dat  = (mode == 1 && i == 2) ? 4'h4 : 4'h0;
      inj_kind = (mode == 3 && i == 0) ? 2'b01 : 2'b00;
      inj_rsv  = (mode == 4 && i == 3);
    end
    @(negedge clk);
    inj_dat = '0; inj_kind = '0; inj_rsv = 1'b0;
    inj_par = (mode == 2);
    check("R3 strobe low in parity cycle", 32'(lk_stb_o), 32'd0);
    check("R4 parity value", 32'(lk_par_o), 32'(exp_par));
    check("R2 ready low in parity cycle", 32'(req_ready), 32'd0);
    @(negedge clk);
    inj_par = 1'b0;
    check("R2 ready after burst", 32'(req_ready), 32'd1);
    check(ok ? "R5 R6 no error" : "R7 R8 error flag", 32'(par_err), 32'(!ok));
    check(ok ? "R6 tracked pulse" : "R7 R8 no tracked pulse",
          32'(cmd_pulse), 32'(ok && k != 2'd0));
    if (ok && k != 2'd0) begin
      check("R6 kind", 32'(cmd_kind), 32'(k));
      check("R6 header", 32'(cmd_hdr), 32'(h));
      check("R6 word", 32'(cmd_word), 32'(w));
    end
    if (ok && k == 2'd0) model[w[11:8]] = w[7:0];
    fs_addr = w[11:8];
    #1;
    check(ok ? "R5 R6 function space" : "R7 R8 function space kept",
          32'(fs_rdata), 32'(model[w[11:8]]));
    if (hold) begin
      req_valid = 1'b0;
      @(negedge clk);
      check("R9 no queued burst", 32'(lk_stb_o), 32'd0);
    end else begin
      @(negedge clk);
    end
    check("R6 R7 pulses are single cycle", 32'({cmd_pulse, par_err}), 32'd0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 16; a++) model[a] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 ready", 32'(req_ready), 32'd1);
    check("R1 strobe", 32'(lk_stb_o), 32'd0);
    check("R1 parity line", 32'(lk_par_o), 32'd0);
    check("R1 reserved", 32'(lk_rsv_o), 32'd0);
    check("R1 pulses", 32'({cmd_pulse, par_err}), 32'd0);
    for (int a = 0; a < 16; a++) begin
      fs_addr = 4'(a);
      #1;
      check("R1 function space zero", 32'(fs_rdata), 32'd0);
    end

    for (int v = 0; v < 8; v++)
      frame(VEC[v][15:14], VEC[v][13:12], VEC[v][11:0], 0, 1'b0);

    frame(2'd0, 2'd0, 12'h3AA, 1, 1'b0);  // R7 data corruption on entry 3
    frame(2'd2, 2'd1, 12'h456, 2, 1'b0);  // R7 parity line corruption
    frame(2'd0, 2'd2, 12'h577, 3, 1'b0);  // R8 kind mismatch on entry 5
    frame(2'd1, 2'd3, 12'h789, 4, 1'b0);  // R8 reserved line high
    frame(2'd0, 2'd1, 12'h95A, 0, 1'b1);  // R9 request held through burst
    frame(2'd0, 2'd0, 12'h5E1, 0, 1'b0);  // R5 entry 5 after discarded write

    for (int a = 0; a < 16; a++) begin
      fs_addr = 4'(a);
      #1;
      check("R5 R7 final function space", 32'(fs_rdata), 32'(model[a]));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule